// File: doc/BRIEF.md
# Serial-Programmed Configuration Register Bank

This block is a three-wire serial slave that loads a bank of configuration registers. A host drives a serial clock, a serial data line and a latch-enable line. While latch-enable is low, each rising serial-clock edge shifts one data bit into a 32-bit frame, most significant bit first. When latch-enable rises, the frame is decoded. The four bits shifted in last give the target address, and the 28 bits that came before them give the value.

The bank is sparse. Nine registers exist: addresses 0 to 7 and address 14. A frame whose address names no register, or that does not hold exactly 32 bits, is dropped. Bit 31 of a frame aimed at address 0 is a self-clearing bank reset. When it is set, every register returns to zero and the other bits of that frame have no effect. A status output goes high once address 14 has been written, which marks the device as configured.

All three serial inputs are asynchronous to the system clock `clk`. Each passes through a synchronizer of `SYNC_STAGES` flops, and its edges are found in the `clk` domain. Register contents are presented in parallel.

Top module: `cfg_serial_bank`

## Requirements
- R1: Frame bits are taken most significant bit first. After 32 bits, frame bits [3:0] are the address and frame bits [31:4] are the 28-bit value.
- R2: A bit is captured only on a rising serial-clock edge while latch-enable is low. Serial-clock edges while latch-enable is high change nothing.
- R3: A rising latch-enable edge commits the value to the addressed register. With the default `SYNC_STAGES` of 2, the output changes on the 4th rising `clk` edge after latch-enable rises. Otherwise the outputs hold their values.
- R4: Only addresses 0 to 7 and 14 are implemented. Output slot k holds address k for k = 0..7, and slot 8 holds address 14. A commit to addresses 8 to 13 or 15 changes no register and no status.
- R5: A frame that holds a number of bits other than 32 when latch-enable rises is discarded.
- R6: A frame to address 0 with frame bit 31 set clears every register to zero and drops `configured_o`. The other bits of that frame are ignored.
- R7: A frame to address 0 with frame bit 31 clear stores its value normally. Bit 27 of slot 0 therefore always reads 0.
- R8: `configured_o` goes high on the commit of a valid frame to address 14 and stays high until a clearing event.
- R9: While `rst_n` is low at a rising `clk` edge, all registers become zero and `configured_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_latch | input | 1 | Latch-enable, asynchronous; a rising edge commits the frame |
| bank_o | output | 9x28 | Register contents, slots 0..8 (slot 8 = address 14) |
| configured_o | output | 1 | High once address 14 has been written |

## Verification
The assertions check these rules on every cycle:
- A latch-enable edge after a wrong bit count never produces a commit.
- An unimplemented address never produces a write.
- The bank holds still when neither a write nor a clear is requested.
- A clear leaves everything at zero.
- The reset bit never stays stored in slot 0.
- The configured flag only rises after a write to address 14.

Some behaviours only the bench's scenarios can show:
- The data arrives in MSB-first order, with the address and the value split at the right place.
- Serial-clock edges while latch-enable is high are ignored.
- The commit shows up at the output exactly four cycles after latch-enable rises.
- Later frames behave correctly after a bank reset.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = WORD_W - ADDR_W;
    localparam int NUM_SLOTS = 9;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int LOW_REGS  = 8;
    localparam int HIGH_ADDR = 14;
    localparam int HIGH_SLOT = LOW_REGS;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SLOT_W-1:0] slot_t;

    function automatic logic addr_present(input addr_t a);
        return (int'(a) < LOW_REGS) || (int'(a) == HIGH_ADDR);
    endfunction

    function automatic slot_t addr_to_slot(input addr_t a);
        return (int'(a) == HIGH_ADDR) ? slot_t'(HIGH_SLOT) : slot_t'(a);
    endfunction
endpackage

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_SAT = WORD_W + 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] ck_sync;
        logic [SYNC_STAGES-1:0] dt_sync;
        logic [SYNC_STAGES-1:0] le_sync;
        logic                   ck_prev;
        logic                   le_prev;
        logic [WORD_W-1:0]      shreg;
        logic [CNT_W-1:0]       cnt;
        logic                   commit;
        logic [WORD_W-1:0]      word;
    } rx_state_t;

    rx_state_t st_q, st_d;
    logic ck_now, dt_now, le_now, ck_rise, le_rise, le_fall;

    assign ck_now  = st_q.ck_sync[SYNC_STAGES-1];
    assign dt_now  = st_q.dt_sync[SYNC_STAGES-1];
    assign le_now  = st_q.le_sync[SYNC_STAGES-1];
    assign ck_rise = ck_now & ~st_q.ck_prev;
    assign le_rise = le_now & ~st_q.le_prev;
    assign le_fall = ~le_now & st_q.le_prev;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_comb begin
                st_d = st_q;
                st_d.ck_sync = {st_q.ck_sync[SYNC_STAGES-2:0], ser_clk};
                st_d.dt_sync = {st_q.dt_sync[SYNC_STAGES-2:0], ser_data};
                st_d.le_sync = {st_q.le_sync[SYNC_STAGES-2:0], ser_latch};
                st_d.ck_prev = ck_now;
                st_d.le_prev = le_now;
                st_d.commit  = 1'b0;
                if (le_rise) begin
                    st_d.commit = (st_q.cnt == CNT_W'(WORD_W));
                    st_d.word   = st_q.shreg;
                    st_d.cnt    = '0;
                end else if (le_fall) begin
                    st_d.cnt    = '0;
                end else if (ck_rise && !le_now) begin
                    st_d.shreg  = {st_q.shreg[WORD_W-2:0], dt_now};
                    if (st_q.cnt != CNT_W'(CNT_SAT))
                        st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.ck_sync = ser_clk;
                st_d.dt_sync = ser_data;
                st_d.le_sync = ser_latch;
                st_d.ck_prev = ck_now;
                st_d.le_prev = le_now;
                st_d.commit  = 1'b0;
                if (le_rise) begin
                    st_d.commit = (st_q.cnt == CNT_W'(WORD_W));
                    st_d.word   = st_q.shreg;
                    st_d.cnt    = '0;
                end else if (le_fall) begin
                    st_d.cnt    = '0;
                end else if (ck_rise && !le_now) begin
                    st_d.shreg  = {st_q.shreg[WORD_W-2:0], dt_now};
                    if (st_q.cnt != CNT_W'(CNT_SAT))
                        st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_o = st_q.commit;
    assign word_o   = st_q.word;

    // R5: wrong bit count never commits
    p_short_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && st_q.cnt != CNT_W'(WORD_W)) |=> !commit_o);

    // R2: counter never runs past saturation
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_SAT));
endmodule

// File: rtl/cfg_word_decode.sv
module cfg_word_decode
    import cfg_pkg::*;
(
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              we_o,
    output slot_t             slot_o,
    output data_t             data_o,
    output logic              clear_o
);
    addr_t addr;
    logic  reset_bit;

    always_comb begin
        addr      = word_i[ADDR_W-1:0];
        reset_bit = word_i[WORD_W-1];
        data_o    = word_i[WORD_W-1:ADDR_W];
        slot_o    = addr_to_slot(addr);
        clear_o   = commit_i && (addr == '0) && reset_bit;
        we_o      = commit_i && addr_present(addr) && !clear_o;
    end
endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
    import cfg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  slot_t                          slot_i,
    input  data_t                          data_i,
    input  logic                           clear_i,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_o,
    output logic                           configured_o
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][DATA_W-1:0] bank;
        logic                             cfg;
    } store_t;

    store_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d = '0;
        end else if (we_i) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (slot_i == slot_t'(k)) s_d.bank[k] = data_i;
            end
            if (slot_i == slot_t'(HIGH_SLOT)) s_d.cfg = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bank_o       = s_q.bank;
    assign configured_o = s_q.cfg;

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !clear_i) |=> $stable(bank_o) && $stable(configured_o));

    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (bank_o == '0) && !configured_o);

    p_reset_bit_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bank_o[0][DATA_W-1] == 1'b0);

    p_cfg_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured_o) |-> $past(we_i && slot_i == slot_t'(HIGH_SLOT)));
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ser_clk,
    input  logic                             ser_data,
    input  logic                             ser_latch,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_o,
    output logic                             configured_o
);
    logic              commit;
    logic [WORD_W-1:0] word;
    logic              we, clear;
    slot_t             slot;
    data_t             data;

    serial_frame_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .commit_o(commit), .word_o(word)
    );

    cfg_word_decode u_dec (
        .commit_i(commit), .word_i(word), .we_o(we), .slot_o(slot),
        .data_o(data), .clear_o(clear)
    );

    cfg_reg_store u_store (
        .clk(clk), .rst_n(rst_n), .we_i(we), .slot_i(slot), .data_i(data),
        .clear_i(clear), .bank_o(bank_o), .configured_o(configured_o)
    );

    p_unimpl_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !addr_present(word[ADDR_W-1:0])) |-> !we && !clear);
endmodule

// File: tb/test_cfg_serial_bank.sv
module test_cfg_serial_bank;
    import cfg_pkg::*;

    logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_latch = 1;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_o;
    logic configured_o;
    int checks = 0, fails = 0;
    int blackout = 0;
    bit compare_on = 0;
    string cur_req = "R9";
    logic [DATA_W-1:0] m_bank [NUM_SLOTS];
    logic m_cfg = 0;

    always #5 clk = ~clk;

    cfg_serial_bank i_cfg_serial_bank (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .bank_o(bank_o), .configured_o(configured_o)
    );

    // reference compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (blackout > 0) blackout--;
        else if (compare_on) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                checks++;
                if (bank_o[k] !== m_bank[k]) begin
                    fails++;
                    $display("FAIL %s slot %0d actual %h expected %h", cur_req, k, bank_o[k], m_bank[k]);
                end
            end
            checks++;
            if (configured_o !== m_cfg) begin
                fails++;
                $display("FAIL %s configured actual %b expected %b", cur_req, configured_o, m_cfg);
            end
        end
    end

    task automatic model_apply(input logic [63:0] w, input int n);
        logic [3:0] a;
        if (n != 32) return;
        a = w[3:0];
        if (a == 0 && w[31]) begin
            for (int k = 0; k < NUM_SLOTS; k++) m_bank[k] = '0;
            m_cfg = 0;
        end else if (a < 8) m_bank[a] = w[31:4];
        else if (a == 14) begin
            m_bank[8] = w[31:4];
            m_cfg = 1;
        end
    endtask

    task automatic send(input logic [63:0] w, input int n, input int noise);
        @(negedge clk);
        // sclk toggles while latch is high: must be ignored (R2)
        for (int i = 0; i < noise; i++) begin
            ser_data = i[0];
            repeat (2) @(negedge clk); ser_clk = 1;
            repeat (2) @(negedge clk); ser_clk = 0;
        end
        ser_latch = 0;
        repeat (3) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            repeat (2) @(negedge clk); ser_clk = 1;
            repeat (2) @(negedge clk); ser_clk = 0;
        end
        repeat (2) @(negedge clk);
        ser_latch = 1;
        // R3: output changes at 4th posedge; check old value holds until then
        @(negedge clk); // after posedge 1
        blackout = 0;
        for (int c = 1; c <= 5; c++) begin
            if (c == 4) model_apply(w, n);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int k = 0; k < NUM_SLOTS; k++) m_bank[k] = '0;
        repeat (3) @(negedge clk);
        compare_on = 1;              // R9: reset state checked while held
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);

        cur_req = "R1";  send({32'hABCD_1233}, 32, 0);
        cur_req = "R3";  send({32'h1234_5671}, 32, 0);
        cur_req = "R1";  send({32'h0FED_CBA7}, 32, 0);
        cur_req = "R2";  send({32'h5555_AAA5}, 32, 6);
        cur_req = "R4";  send({32'hFFFF_FFF9}, 32, 0);
        cur_req = "R4";  send({32'hFFFF_FFFF}, 32, 0);
        cur_req = "R4";  send({32'h7777_777C}, 32, 0);
        cur_req = "R5";  send({32'h1111_1112}, 31, 0);
        cur_req = "R5";  send({33'h1_2222_2224}, 33, 0);
        cur_req = "R7";  send({32'h7654_3210}, 32, 0);
        cur_req = "R8";  send({32'h0BAD_F00E}, 32, 0);
        cur_req = "R8";  send({32'h0C0F_FEEE}, 32, 0);
        cur_req = "R6";  send({32'hFFFF_FFF0}, 32, 0);
        cur_req = "R6";  send({32'h0000_0056}, 32, 0);
        cur_req = "R8";  send({32'h0123_456E}, 32, 0);
        cur_req = "R9";
        @(negedge clk); rst_n = 0;
        for (int k = 0; k < NUM_SLOTS; k++) m_bank[k] = '0;
        m_cfg = 0;
        blackout = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule